// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the software-visible configuration state of a DDR SDRAM controller. It sits on a simple device-control register bus and takes up only two bus register numbers. One of them is an index port and the other is a data port. Software first writes an internal register offset to the index port. Reads and writes on the data port then reach the register selected by that offset. Each internal register applies its own write mask, forced bits and reset value.

Writes to the configuration word are watched for edges on its two top bits, and the read-only status word follows those edges. A write to the ECC error-status word that moves it between zero and nonzero raises or lowers an interrupt line. The global enable and the bank-configuration words are driven out as registered outputs for a bank decoder. That decoder turns on the populated banks when the enable is set.

A bus access is a one-cycle request: `ctl_req` is high, `ctl_we` selects the direction, and `ctl_num` gives the bus register number. Read data appears on `ctl_rdata` on the clock edge that accepts the read. It stays there until the next read of one of this block's two numbers.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write to bus number ADDR_NUM (default 0x10) stores the low 8 bits of write data as the current offset. The offset resets to 0. A read of ADDR_NUM returns the offset zero-extended to 32 bits.
- R2: A read of bus number DATA_NUM (default 0x11) loads `ctl_rdata`, on the accepting edge, with the register at the current offset. An offset that holds no register reads as 0.
- R3: A data write stores the value under these masks: refresh timer (offset 0x30) keeps val & 0x3FF80000, timing (0x80) keeps val & 0x018FC01F, and ECC config (0x94) keeps val & 0x00F00000. Error status 0 (0x00), error status 1 (0x08), error address (0x10), configuration (0x20) and ECC error status (0x98) keep all 32 bits.
- R4: The power-management timer (0x34) stores (val & 0xF8000000) | 0x07C00000 and resets to 0x07C00000.
- R5: Bank word i sits at offset 0x40 + 4*i. It stores val & 0xFFDEE001, resets to 0, and is driven on `bank_cfg[32*i+31 : 32*i]`.
- R6: The status word (0x24) resets to 0x80000000. A configuration write that takes bit 31 from 0 to 1 clears status bit 31, and one that takes it from 1 to 0 sets it. `sdram_en` equals configuration bit 31.
- R7: A configuration write that takes bit 30 from 0 to 1 sets status bit 30, and one that takes it from 1 to 0 clears it.
- R8: A data write to the status offset changes nothing.
- R9: A write that takes ECC error status from zero to nonzero sets `ecc_irq`. A write from nonzero to zero clears it. Other writes leave it unchanged.
- R10: Error status 0 and 1, error address, configuration, refresh timer, timing, ECC config and ECC error status all reset to 0, and `ecc_irq` resets low.
- R11: A data write to an offset that holds no register changes nothing. A bus access to any number other than the two ports changes neither the offset nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_req | input | 1 | Bus access strobe, one cycle per access |
| ctl_we | input | 1 | 1 = write, 0 = read |
| ctl_num | input | NUM_W | Bus register number |
| ctl_wdata | input | 32 | Write data |
| ctl_rdata | output | 32 | Registered read data |
| sdram_en | output | 1 | Global SDRAM enable (configuration bit 31) |
| bank_cfg | output | 32*NBANK | Bank configuration words, bank i at bits 32*i+31:32*i |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The bench builds the block with its default parameters: four banks, a 10-bit bus number, and the ports at 0x10 and 0x11. With those defaults every bank offset up to 0x4C can be reached, and the full 8-bit offset range, including 0xFF, can be tested through the index port. A behavioural model keeps the registers in an associative array keyed by offset. On every clock it is compared against the enable, bank and interrupt outputs, and against the read data after each read. The stimulus covers both edge directions on both configuration bits, interrupt writes from nonzero to nonzero, and accesses to unused offsets and foreign bus numbers.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DW    = 32;
  localparam int OFF_W = 8;

  localparam logic [OFF_W-1:0] O_ES0   = 8'h00;
  localparam logic [OFF_W-1:0] O_ES1   = 8'h08;
  localparam logic [OFF_W-1:0] O_EA    = 8'h10;
  localparam logic [OFF_W-1:0] O_CFG   = 8'h20;
  localparam logic [OFF_W-1:0] O_STAT  = 8'h24;
  localparam logic [OFF_W-1:0] O_RTR   = 8'h30;
  localparam logic [OFF_W-1:0] O_PMIT  = 8'h34;
  localparam logic [OFF_W-1:0] O_BANK0 = 8'h40;
  localparam logic [OFF_W-1:0] O_TR    = 8'h80;
  localparam logic [OFF_W-1:0] O_ECFG  = 8'h94;
  localparam logic [OFF_W-1:0] O_EESR  = 8'h98;

  localparam logic [DW-1:0] RTR_MASK  = 32'h3FF8_0000;
  localparam logic [DW-1:0] TR_MASK   = 32'h018F_C01F;
  localparam logic [DW-1:0] ECFG_MASK = 32'h00F0_0000;
  localparam logic [DW-1:0] BANK_MASK = 32'hFFDE_E001;
  localparam logic [DW-1:0] PMIT_KEEP = 32'hF800_0000;
  localparam logic [DW-1:0] PMIT_SET  = 32'h07C0_0000;
  localparam logic [DW-1:0] STAT_RST  = 32'h8000_0000;
endpackage

// File: rtl/scr_index.sv
module scr_index
  import scr_pkg::*;
#(
  parameter int NUM_W = 10,
  parameter logic [NUM_W-1:0] ADDR_NUM = 10'h010,
  parameter logic [NUM_W-1:0] DATA_NUM = 10'h011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [NUM_W-1:0] num,
  input  logic [OFF_W-1:0] wdata_lo,
  output logic [OFF_W-1:0] off,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic             idx_rd
);
  logic hit_idx, hit_dat;

  assign hit_idx = req && (num == ADDR_NUM);
  assign hit_dat = req && (num == DATA_NUM);
  assign reg_wr  = hit_dat && we;
  assign reg_rd  = hit_dat && !we;
  assign idx_rd  = hit_idx && !we;

  always_ff @(posedge clk) begin
    if (rst)                off <= '0;
    else if (hit_idx && we) off <= wdata_lo;
  end
endmodule

// File: rtl/scr_store.sv
module scr_store
  import scr_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [OFF_W-1:0]   off,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rd_val,
  output logic               en,
  output logic [NBANK*DW-1:0] banks,
  output logic               irq
);
  logic [DW-1:0] es0_q, es1_q, ea_q, cfg_q, stat_q, rtr_q, pmit_q, tr_q, ecfg_q, eesr_q;
  logic [DW-1:0] bank_q [NBANK];

  always_ff @(posedge clk) begin
    if (rst) begin
      es0_q  <= '0;
      es1_q  <= '0;
      ea_q   <= '0;
      cfg_q  <= '0;
      stat_q <= STAT_RST;
      rtr_q  <= '0;
      pmit_q <= PMIT_SET;
      tr_q   <= '0;
      ecfg_q <= '0;
      eesr_q <= '0;
      irq    <= 1'b0;
    end else if (wr) begin
      case (off)
        O_ES0: es0_q <= wdata;
        O_ES1: es1_q <= wdata;
        O_EA:  ea_q  <= wdata;
        O_CFG: begin
          cfg_q <= wdata;
          if (!cfg_q[31] && wdata[31])      stat_q[31] <= 1'b0;
          else if (cfg_q[31] && !wdata[31]) stat_q[31] <= 1'b1;
          if (!cfg_q[30] && wdata[30])      stat_q[30] <= 1'b1;
          else if (cfg_q[30] && !wdata[30]) stat_q[30] <= 1'b0;
        end
        O_RTR:  rtr_q  <= wdata & RTR_MASK;
        O_PMIT: pmit_q <= (wdata & PMIT_KEEP) | PMIT_SET;
        O_TR:   tr_q   <= wdata & TR_MASK;
        O_ECFG: ecfg_q <= wdata & ECFG_MASK;
        O_EESR: begin
          eesr_q <= wdata;
          if (eesr_q == '0 && wdata != '0)      irq <= 1'b1;
          else if (eesr_q != '0 && wdata == '0) irq <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    localparam logic [OFF_W-1:0] BOFF = O_BANK0 + OFF_W'(gi * 4);
    always_ff @(posedge clk) begin
      if (rst)                    bank_q[gi] <= '0;
      else if (wr && off == BOFF) bank_q[gi] <= wdata & BANK_MASK;
    end
    assign banks[gi*DW +: DW] = bank_q[gi];
  end

  assign en = cfg_q[31];

  always_comb begin
    case (off)
      O_ES0:   rd_val = es0_q;
      O_ES1:   rd_val = es1_q;
      O_EA:    rd_val = ea_q;
      O_CFG:   rd_val = cfg_q;
      O_STAT:  rd_val = stat_q;
      O_RTR:   rd_val = rtr_q;
      O_PMIT:  rd_val = pmit_q;
      O_TR:    rd_val = tr_q;
      O_ECFG:  rd_val = ecfg_q;
      O_EESR:  rd_val = eesr_q;
      default: rd_val = '0;
    endcase
    for (int i = 0; i < NBANK; i++) begin
      if (off == O_BANK0 + OFF_W'(i * 4)) rd_val = bank_q[i];
    end
  end
endmodule

// File: rtl/scr_readout.sv
module scr_readout
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_rd,
  input  logic             idx_rd,
  input  logic [OFF_W-1:0] off,
  input  logic [DW-1:0]    rd_val,
  output logic [DW-1:0]    rdata
);
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (idx_rd) rdata <= {{(DW-OFF_W){1'b0}}, off};
    else if (reg_rd) rdata <= rd_val;
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import scr_pkg::*;
#(
  parameter int NUM_W = 10,
  parameter logic [NUM_W-1:0] ADDR_NUM = 10'h010,
  parameter logic [NUM_W-1:0] DATA_NUM = 10'h011,
  parameter int NBANK = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_req,
  input  logic                ctl_we,
  input  logic [NUM_W-1:0]    ctl_num,
  input  logic [DW-1:0]       ctl_wdata,
  output logic [DW-1:0]       ctl_rdata,
  output logic                sdram_en,
  output logic [NBANK*DW-1:0] bank_cfg,
  output logic                ecc_irq
);
  logic [OFF_W-1:0] cur_off;
  logic             reg_wr, reg_rd, idx_rd;
  logic [DW-1:0]    rd_val;

  scr_index #(.NUM_W(NUM_W), .ADDR_NUM(ADDR_NUM), .DATA_NUM(DATA_NUM)) u_index (
    .clk(clk), .rst(rst), .req(ctl_req), .we(ctl_we), .num(ctl_num),
    .wdata_lo(ctl_wdata[OFF_W-1:0]), .off(cur_off),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .idx_rd(idx_rd)
  );

  scr_store #(.NBANK(NBANK)) u_store (
    .clk(clk), .rst(rst), .wr(reg_wr), .off(cur_off), .wdata(ctl_wdata),
    .rd_val(rd_val), .en(sdram_en), .banks(bank_cfg), .irq(ecc_irq)
  );

  scr_readout u_readout (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .idx_rd(idx_rd),
    .off(cur_off), .rd_val(rd_val), .rdata(ctl_rdata)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
#(
  parameter int NUM_W = 10,
  parameter logic [NUM_W-1:0] ADDR_NUM = 10'h010,
  parameter int NBANK = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                ctl_req,
  input logic                ctl_we,
  input logic [NUM_W-1:0]    ctl_num,
  input logic [DW-1:0]       ctl_wdata,
  input logic                sdram_en,
  input logic [NBANK*DW-1:0] bank_cfg,
  input logic                ecc_irq,
  input logic [OFF_W-1:0]    cur_off,
  input logic                reg_wr
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (ctl_req && ctl_we && ctl_num == ADDR_NUM) |=> cur_off == $past(ctl_wdata[OFF_W-1:0]));

  a_r5_bank_mask: assert property (@(posedge clk) disable iff (rst)
    (bank_cfg & ~{NBANK{BANK_MASK}}) == '0);

  a_r6_enable_follows: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && cur_off == O_CFG) |=> sdram_en == $past(ctl_wdata[31]));

  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && cur_off == O_EESR && ctl_wdata != '0 && !ecc_irq) |=> ecc_irq);

  a_r9_irq_lower: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && cur_off == O_EESR && ctl_wdata == '0) |=> !ecc_irq);

  a_r11_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(sdram_en) && $stable(bank_cfg) && $stable(ecc_irq)));
endmodule

bind sdram_cfg_regs scr_checker #(.NUM_W(NUM_W), .ADDR_NUM(ADDR_NUM), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst(rst), .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_num(ctl_num),
  .ctl_wdata(ctl_wdata), .sdram_en(sdram_en), .bank_cfg(bank_cfg), .ecc_irq(ecc_irq),
  .cur_off(cur_off), .reg_wr(reg_wr)
);

// File: tb/sdram_cfg_regs_bench.sv
module sdram_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  num = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        en, irq;
  logic [127:0] banks;

  int tests = 0, fails = 0;

  logic [31:0] mr [int];
  logic [7:0]  m_off;
  logic        m_irq;
  logic [31:0] m_rdata;
  logic        m_rd_pend;
  logic        live = 1'b0;

  always #2 clk = ~clk;

  sdram_cfg_regs u_sdram_cfg_regs (
    .clk(clk), .rst(rst), .ctl_req(req), .ctl_we(we), .ctl_num(num),
    .ctl_wdata(wd), .ctl_rdata(rdata), .sdram_en(en), .bank_cfg(banks), .ecc_irq(irq)
  );

  function automatic logic [31:0] mread(input int o);
    return mr.exists(o) ? mr[o] : 32'h0;
  endfunction

  task automatic model_reset();
    mr.delete();
    foreach (mr[k]) mr[k] = 0;
    mr[8'h00] = 0; mr[8'h08] = 0; mr[8'h10] = 0; mr[8'h20] = 0;
    mr[8'h24] = 32'h8000_0000; mr[8'h30] = 0; mr[8'h34] = 32'h07C0_0000;
    mr[8'h40] = 0; mr[8'h44] = 0; mr[8'h48] = 0; mr[8'h4C] = 0;
    mr[8'h80] = 0; mr[8'h94] = 0; mr[8'h98] = 0;
    m_off = 0; m_irq = 0; m_rdata = 0; m_rd_pend = 0;
  endtask

  task automatic model_write(input int o, input logic [31:0] d);
    case (o)
      8'h00, 8'h08, 8'h10: mr[o] = d;
      8'h20: begin
        if (!mr[o][31] && d[31]) mr[8'h24][31] = 1'b0;
        if (mr[o][31] && !d[31]) mr[8'h24][31] = 1'b1;
        if (!mr[o][30] && d[30]) mr[8'h24][30] = 1'b1;
        if (mr[o][30] && !d[30]) mr[8'h24][30] = 1'b0;
        mr[o] = d;
      end
      8'h30: mr[o] = d & 32'h3FF8_0000;
      8'h34: mr[o] = (d & 32'hF800_0000) | 32'h07C0_0000;
      8'h40, 8'h44, 8'h48, 8'h4C: mr[o] = d & 32'hFFDE_E001;
      8'h80: mr[o] = d & 32'h018F_C01F;
      8'h94: mr[o] = d & 32'h00F0_0000;
      8'h98: begin
        if (mr[o] == 0 && d != 0) m_irq = 1'b1;
        if (mr[o] != 0 && d == 0) m_irq = 1'b0;
        mr[o] = d;
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (live && !rst) begin
      check("R6 sdram_en vs model", {31'b0, en}, {31'b0, mread(8'h20) >> 31});
      check("R9 ecc_irq vs model", {31'b0, irq}, {31'b0, m_irq});
      for (int b = 0; b < 4; b++)
        check("R5 bank_cfg vs model", banks[b*32 +: 32], mread(8'h40 + 4*b));
      if (m_rd_pend) begin
        check("R2 read data vs model", rdata, m_rdata);
        m_rd_pend = 0;
      end
    end
  end

  task automatic bus(input logic w, input logic [9:0] n, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; num = n; wd = d;
    @(posedge clk);
    if (n == 10'h010) begin
      if (w) m_off = d[7:0];
      else begin m_rdata = {24'h0, m_off}; m_rd_pend = 1; end
    end else if (n == 10'h011) begin
      if (w) model_write(int'(m_off), d);
      else begin m_rdata = mread(int'(m_off)); m_rd_pend = 1; end
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] o, input logic [31:0] d);
    bus(1'b1, 10'h010, {24'h0, o});
    bus(1'b1, 10'h011, d);
  endtask

  task automatic rd_reg(input logic [7:0] o, input logic [31:0] exp, input string tag);
    bus(1'b1, 10'h010, {24'h0, o});
    bus(1'b0, 10'h011, 32'h0);
    check(tag, rdata, exp);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // reset state
    bus(1'b0, 10'h010, 0);
    check("R1 offset after reset", rdata, 32'h0);
    check("R5 bank_cfg after reset", banks[31:0] | banks[127:96], 32'h0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    rd_reg(8'h24, 32'h8000_0000, "R6 status reset");
    rd_reg(8'h34, 32'h07C0_0000, "R4 pm timer reset");
    rd_reg(8'h20, 32'h0, "R10 config reset");
    rd_reg(8'h98, 32'h0, "R10 ecc err status reset");
    rd_reg(8'h94, 32'h0, "R10 ecc config reset");
    rd_reg(8'h00, 32'h0, "R10 err status 0 reset");

    // masks
    wr_reg(8'h30, 32'hFFFF_FFFF); rd_reg(8'h30, 32'h3FF8_0000, "R3 refresh mask");
    wr_reg(8'h80, 32'hFFFF_FFFF); rd_reg(8'h80, 32'h018F_C01F, "R3 timing mask");
    wr_reg(8'h94, 32'hFFFF_FFFF); rd_reg(8'h94, 32'h00F0_0000, "R3 ecc config mask");
    wr_reg(8'h08, 32'hA5A5_5A5A); rd_reg(8'h08, 32'hA5A5_5A5A, "R3 err status 1 full");
    wr_reg(8'h10, 32'h1234_5678); rd_reg(8'h10, 32'h1234_5678, "R3 err address full");
    wr_reg(8'h34, 32'h0);         rd_reg(8'h34, 32'h07C0_0000, "R4 pm timer forced bits");
    wr_reg(8'h34, 32'hFFFF_FFFF); rd_reg(8'h34, 32'hFFC0_0000, "R4 pm timer all ones");

    // banks
    wr_reg(8'h40, 32'hFFFF_FFFF);
    check("R5 bank0 port", banks[31:0], 32'hFFDE_E001);
    wr_reg(8'h48, 32'h0080_0001);
    check("R5 bank2 port", banks[95:64], 32'h0080_0001);
    wr_reg(8'h4C, 32'h0001_1FFE);
    check("R5 bank3 port", banks[127:96], 32'h0);
    rd_reg(8'h48, 32'h0080_0001, "R5 bank2 read");

    // configuration edges
    wr_reg(8'h20, 32'hC000_0000);
    check("R6 enable set", {31'b0, en}, 32'h1);
    rd_reg(8'h24, 32'h4000_0000, "R6 R7 status after rise");
    wr_reg(8'h20, 32'h8000_0000);
    rd_reg(8'h24, 32'h0000_0000, "R7 status after bit30 fall");
    wr_reg(8'h20, 32'h0);
    check("R6 enable clear", {31'b0, en}, 32'h0);
    rd_reg(8'h24, 32'h8000_0000, "R6 status after fall");

    // status read-only
    wr_reg(8'h24, 32'h0);
    rd_reg(8'h24, 32'h8000_0000, "R8 status write ignored");

    // interrupt
    wr_reg(8'h98, 32'h5);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    wr_reg(8'h98, 32'h7);
    check("R9 irq held", {31'b0, irq}, 32'h1);
    wr_reg(8'h98, 32'h0);
    check("R9 irq lowered", {31'b0, irq}, 32'h0);

    // unimplemented offset and foreign numbers
    wr_reg(8'h04, 32'hFFFF_FFFF);
    rd_reg(8'h04, 32'h0, "R11 hole reads zero");
    rd_reg(8'h00, 32'h0, "R11 neighbour untouched");
    bus(1'b1, 10'h010, 32'h0000_0020);
    bus(1'b1, 10'h012, 32'h0000_0098);
    bus(1'b1, 10'h110, 32'h0000_0098);
    bus(1'b0, 10'h010, 0);
    check("R11 foreign number keeps offset", rdata, 32'h20);
    bus(1'b1, 10'h010, 32'h0000_01FF);
    bus(1'b0, 10'h010, 0);
    check("R1 offset low byte", rdata, 32'hFF);
    bus(1'b0, 10'h011, 0);
    check("R2 hole read at 0xFF", rdata, 32'h0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule